// File: doc/BRIEF.md
# Double-Buffered Pixel Color Matrix

This block converts each pixel of a video stream from one three-channel color space to another. It multiplies the pixel by a 3x3 coefficient matrix and adds a per-row offset. It then rounds the result and clamps it to the pixel range.

The block holds two full coefficient sets, called bank A and bank B. Software fills the bank that is idle and then writes a new mode. The new mode waits until the next frame-start pulse before it takes effect, so a frame never mixes two coefficient sets. Software can read the applied mode on a status output, which tells it which bank is free to rewrite. A third mode, bypass, takes the matrix out of the path.

Bypass keeps the same two-cycle delay as the matrix path, so switching modes never shifts pixel timing.

Top module: `csc_pingpong`

## Requirements
- R1: After synchronous reset, `active_mode` is 0 (bypass), `pix_valid_out` is 0, and both banks hold the identity matrix (coefficient indices 0, 5 and 10 equal 8192, all others 0).
- R2: Write port address map. Address 0..5 are bank A words and address 8..13 are bank B words. Within a word, bits [15:0] hold coefficient 2k and bits [31:16] hold coefficient 2k+1, where k is the word number. Coefficients are numbered row by row, so index `4*row+col` holds Crc. Address 15 is the mode register, using bits [1:0]: 0 is bypass, 1 is bank A, 2 is bank B, and 3 acts as bypass. Writes to address 6, 7 and 14 change nothing.
- R3: A mode write only sets a pending mode. `active_mode` keeps its value until a `frame_start` pulse arrives.
- R4: On a clock where `frame_start` is 1, the active mode takes the pending value. A pixel presented in that same cycle is already processed with the new mode.
- R5: A coefficient write to the bank that is currently active is ignored. Writes to the other bank are accepted, and in bypass both banks are writable.
- R6: Pixels are packed with channel 1 in [11:0], channel 2 in [23:12] and channel 3 in [35:24], all unsigned. For each row r, output channel r equals Cr1*in1 + Cr2*in2 + Cr3*in3 + Cr4. Cr1..Cr3 are signed 16-bit values with 13 fraction bits. Cr4 is a signed integer offset in output units.
- R7: The result is rounded half up, meaning 2^12 is added before the 13-bit arithmetic right shift. It is then clamped to the range 0..4095.
- R8: In bypass mode, output pixels equal input pixels bit for bit.
- R9: Every valid input pixel produces exactly one valid output exactly two clocks later, in every mode.
- R10: When a mode write and `frame_start` occur in the same cycle, the active mode takes the previously pending value, and the newly written value stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data (two coefficients) |
| frame_start | input | 1 | One-cycle pulse at the frame boundary |
| active_mode | output | 2 | Mode currently applied to pixels |
| pix_valid_in | input | 1 | Input pixel qualifier |
| pix_in | input | 36 | Input pixel, three 12-bit channels |
| pix_valid_out | output | 1 | Output pixel qualifier |
| pix_out | output | 36 | Output pixel, three 12-bit channels |

## Verification
The bench targets several corner cases, each with the failure a wrong design would show:

- **Frame-boundary cycle.** A pixel arrives together with `frame_start`. A design that switches one cycle late would process that pixel with the old bank.
- **Mode write on the boundary.** A mode write lands on the same cycle as `frame_start`. A design that forwards the new value straight to the active mode would skip the queued bank.
- **Writes into the live bank.** A design that accepts these would corrupt the frame on screen, and the next pixels would show changed values.
- **Arithmetic edges.** The coefficients drive results above 4095, below zero, and exactly onto a half step. Wrong clamping shows up as a wrapped value, and wrong rounding as an off-by-one channel.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_BANK_A = 2'd1,
        MODE_BANK_B = 2'd2
    } csc_mode_e;

    localparam int unsigned CSC_ROWS  = 3;
    localparam int unsigned CSC_COLS  = 4;
    localparam int unsigned CSC_COEFS = CSC_ROWS * CSC_COLS;
    localparam int unsigned CSC_WORDS = CSC_COEFS / 2;
    localparam int unsigned ADDR_W    = 4;
    localparam logic [ADDR_W-1:0] MODE_ADDR = 4'hF;

    typedef struct packed {
        logic      valid;
        csc_mode_e mode;
    } stage_ctl_t;

    function automatic csc_mode_e decode_mode(input logic [1:0] raw);
        case (raw)
            2'd1:    return MODE_BANK_A;
            2'd2:    return MODE_BANK_B;
            default: return MODE_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
    import csc_pkg::*;
#(
    parameter int unsigned COEF_W = 16,
    parameter int unsigned FRAC_W = 13
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_hit,
    input  logic [2:0]                    wr_word,
    input  logic [2*COEF_W-1:0]           wr_data,
    input  logic                          locked,
    output logic [CSC_COEFS*COEF_W-1:0]   coefs
);
    localparam logic [COEF_W-1:0] ONE = COEF_W'(1) << FRAC_W;

    for (genvar w = 0; w < CSC_WORDS; w++) begin : g_word
        localparam int unsigned IDX_LO = 2 * w;
        localparam int unsigned IDX_HI = 2 * w + 1;
        localparam logic [COEF_W-1:0] RST_LO = (IDX_LO % 5 == 0) ? ONE : '0;
        localparam logic [COEF_W-1:0] RST_HI = (IDX_HI % 5 == 0) ? ONE : '0;

        logic [COEF_W-1:0] lo_q, hi_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q <= RST_LO;
                hi_q <= RST_HI;
            end else if (wr_hit && !locked && (wr_word == 3'(w))) begin
                lo_q <= wr_data[COEF_W-1:0];
                hi_q <= wr_data[2*COEF_W-1:COEF_W];
            end
        end

        assign coefs[IDX_LO*COEF_W +: COEF_W] = lo_q;
        assign coefs[IDX_HI*COEF_W +: COEF_W] = hi_q;
    end

    // R5: a bank in use never changes under a write
    p_locked_bank_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && locked) |=> $stable(coefs));

endmodule

// File: rtl/csc_mode_ctrl.sv
module csc_mode_ctrl
    import csc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mode_wr,
    input  logic [1:0] mode_raw,
    input  logic      frame_start,
    output csc_mode_e active,
    output csc_mode_e pixel_mode
);
    csc_mode_e pending_q, active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= MODE_BYPASS;
            active_q  <= MODE_BYPASS;
        end else begin
            if (frame_start) active_q  <= pending_q;
            if (mode_wr)     pending_q <= decode_mode(mode_raw);
        end
    end

    assign active     = active_q;
    assign pixel_mode = frame_start ? pending_q : active_q;

    // R3: the applied mode only moves at a frame boundary
    p_hold_until_frame_r3: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(active_q));

    // R4 / R10: the boundary applies the mode that was pending before it
    p_take_pending_r4: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (active_q == $past(pending_q)));

endmodule

// File: rtl/csc_matrix_path.sv
module csc_matrix_path
    import csc_pkg::*;
#(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned COEF_W = 16,
    parameter int unsigned FRAC_W = 13
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [CSC_ROWS*DATA_W-1:0]  in_pix,
    input  csc_mode_e                   mode,
    input  logic [CSC_COEFS*COEF_W-1:0] coef_a,
    input  logic [CSC_COEFS*COEF_W-1:0] coef_b,
    output logic                        out_valid,
    output logic [CSC_ROWS*DATA_W-1:0]  out_pix
);
    localparam int unsigned PROD_W = COEF_W + DATA_W + 1;
    localparam int unsigned ACC_W  = PROD_W + 3;
    localparam logic signed [ACC_W-1:0] RND = ACC_W'(1) << (FRAC_W - 1);

    logic [CSC_COEFS*COEF_W-1:0] coef_sel;
    stage_ctl_t                  s1_ctl;
    logic [CSC_ROWS*DATA_W-1:0]  s1_pix;

    always_comb coef_sel = (mode == MODE_BANK_B) ? coef_b : coef_a;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_ctl    <= '{valid: 1'b0, mode: MODE_BYPASS};
            s1_pix    <= '0;
            out_valid <= 1'b0;
        end else begin
            s1_ctl.valid <= in_valid;
            out_valid    <= s1_ctl.valid;
            if (in_valid) begin
                s1_ctl.mode <= mode;
                s1_pix      <= in_pix;
            end
        end
    end

    for (genvar r = 0; r < CSC_ROWS; r++) begin : g_row
        logic signed [PROD_W-1:0] prod_d [CSC_ROWS];
        logic signed [PROD_W-1:0] prod_q [CSC_ROWS];
        logic signed [COEF_W-1:0] off_q;
        logic signed [ACC_W-1:0]  acc;
        logic signed [ACC_W-1:0]  off_ext;
        logic        [DATA_W-1:0] sat_d;
        logic        [DATA_W-1:0] res_q;
        logic                     unused_frac;

        always_comb begin
            for (int c = 0; c < CSC_ROWS; c++) begin
                prod_d[c] = $signed(coef_sel[(r*CSC_COLS+c)*COEF_W +: COEF_W])
                          * $signed({1'b0, in_pix[c*DATA_W +: DATA_W]});
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int c = 0; c < CSC_ROWS; c++) prod_q[c] <= '0;
                off_q <= '0;
            end else if (in_valid) begin
                for (int c = 0; c < CSC_ROWS; c++) prod_q[c] <= prod_d[c];
                off_q <= $signed(coef_sel[(r*CSC_COLS+CSC_ROWS)*COEF_W +: COEF_W]);
            end
        end

        always_comb begin
            off_ext = ACC_W'(off_q);
            acc = ACC_W'(prod_q[0]) + ACC_W'(prod_q[1]) + ACC_W'(prod_q[2])
                + (off_ext <<< FRAC_W) + RND;
            if (acc[ACC_W-1])
                sat_d = '0;
            else if (|acc[ACC_W-2:FRAC_W+DATA_W])
                sat_d = '1;
            else
                sat_d = acc[FRAC_W+DATA_W-1:FRAC_W];
        end
        assign unused_frac = ^acc[FRAC_W-1:0];

        always_ff @(posedge clk) begin
            if (rst)
                res_q <= '0;
            else if (s1_ctl.valid)
                res_q <= (s1_ctl.mode == MODE_BYPASS) ? s1_pix[r*DATA_W +: DATA_W] : sat_d;
        end

        assign out_pix[r*DATA_W +: DATA_W] = res_q;
    end

    // R9: output valid appears exactly two clocks after an input valid
    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    // R8: a bypass pixel leaves the pipeline untouched
    p_bypass_pass_r8: assert property (@(posedge clk) disable iff (rst)
        (s1_ctl.valid && s1_ctl.mode == MODE_BYPASS) |=> (out_pix == $past(s1_pix)));

endmodule

// File: rtl/csc_pingpong.sv
module csc_pingpong
    import csc_pkg::*;
#(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned COEF_W = 16,
    parameter int unsigned FRAC_W = 13
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [2*COEF_W-1:0]        wr_data,
    input  logic                       frame_start,
    output logic [1:0]                 active_mode,
    input  logic                       pix_valid_in,
    input  logic [CSC_ROWS*DATA_W-1:0] pix_in,
    output logic                       pix_valid_out,
    output logic [CSC_ROWS*DATA_W-1:0] pix_out
);
    logic       word_ok, mode_wr, hit_a, hit_b;
    logic [2:0] word;
    csc_mode_e  active, pixel_mode;
    logic [CSC_COEFS*COEF_W-1:0] coef_a, coef_b;

    assign word    = wr_addr[2:0];
    assign word_ok = (word < 3'(CSC_WORDS));
    assign mode_wr = wr_en && (wr_addr == MODE_ADDR);
    assign hit_a   = wr_en && !wr_addr[3] && word_ok;
    assign hit_b   = wr_en &&  wr_addr[3] && word_ok;

    csc_mode_ctrl u_mode (
        .clk        (clk),
        .rst        (rst),
        .mode_wr    (mode_wr),
        .mode_raw   (wr_data[1:0]),
        .frame_start(frame_start),
        .active     (active),
        .pixel_mode (pixel_mode)
    );

    csc_coef_bank #(.COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_bank_a (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (hit_a),
        .wr_word(word),
        .wr_data(wr_data),
        .locked (active == MODE_BANK_A),
        .coefs  (coef_a)
    );

    csc_coef_bank #(.COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_bank_b (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (hit_b),
        .wr_word(word),
        .wr_data(wr_data),
        .locked (active == MODE_BANK_B),
        .coefs  (coef_b)
    );

    csc_matrix_path #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_path (
        .clk      (clk),
        .rst      (rst),
        .in_valid (pix_valid_in),
        .in_pix   (pix_in),
        .mode     (pixel_mode),
        .coef_a   (coef_a),
        .coef_b   (coef_b),
        .out_valid(pix_valid_out),
        .out_pix  (pix_out)
    );

    assign active_mode = active;

endmodule

// File: tb/csc_pingpong_bench.sv
module csc_pingpong_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        frame_start = 1'b0;
    logic [1:0]  active_mode;
    logic        pix_valid_in = 1'b0;
    logic [35:0] pix_in = '0;
    logic        pix_valid_out;
    logic [35:0] pix_out;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    csc_pingpong u_csc_pingpong (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_start(frame_start), .active_mode(active_mode),
        .pix_valid_in(pix_valid_in), .pix_in(pix_in),
        .pix_valid_out(pix_valid_out), .pix_out(pix_out)
    );

    // behavioural reference model
    logic [15:0] mbank [2][12];
    int          m_pend, m_act;
    logic        m_v1, m_v2;
    logic [35:0] m_p1, m_p2;

    function automatic logic [35:0] model_px(int em, logic [35:0] px);
        logic [35:0] o;
        longint acc;
        if (em == 0) return px;
        for (int r = 0; r < 3; r++) begin
            acc = 0;
            for (int c = 0; c < 3; c++)
                acc += longint'($signed(mbank[em-1][r*4+c])) * longint'(px[c*12 +: 12]);
            acc += longint'($signed(mbank[em-1][r*4+3])) * 8192;
            acc += 4096;
            acc = acc >>> 13;
            if (acc < 0) acc = 0;
            if (acc > 4095) acc = 4095;
            o[r*12 +: 12] = acc[11:0];
        end
        return o;
    endfunction

    always @(posedge clk) begin
        int em;
        if (rst) begin
            for (int b = 0; b < 2; b++)
                for (int i = 0; i < 12; i++)
                    mbank[b][i] = (i % 5 == 0) ? 16'd8192 : 16'd0;
            m_pend = 0; m_act = 0; m_v1 = 0; m_v2 = 0; m_p1 = '0; m_p2 = '0;
        end else begin
            em = frame_start ? m_pend : m_act;
            m_v2 = m_v1; m_p2 = m_p1;
            m_v1 = pix_valid_in;
            if (pix_valid_in) m_p1 = model_px(em, pix_in);
            if (wr_en && wr_addr != 4'hF && wr_addr[2:0] < 3'd6) begin
                if (m_act != int'(wr_addr[3]) + 1) begin
                    mbank[wr_addr[3]][2*wr_addr[2:0]]   = wr_data[15:0];
                    mbank[wr_addr[3]][2*wr_addr[2:0]+1] = wr_data[31:16];
                end
            end
            if (frame_start) m_act = m_pend;
            if (wr_en && wr_addr == 4'hF)
                m_pend = (wr_data[1:0] == 2'd1) ? 1 : (wr_data[1:0] == 2'd2) ? 2 : 0;
        end
    end

    task automatic check(string req, logic [35:0] act, logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            check({cur_req, " valid"}, 36'(pix_valid_out), 36'(m_v2));
            if (m_v2) check({cur_req, " pixel"}, pix_out, m_p2);
        end
    end

    task automatic step();
        @(negedge clk);
        wr_en = 0; frame_start = 0; pix_valid_in = 0;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d; step();
    endtask

    task automatic px(logic [35:0] p);
        pix_valid_in = 1; pix_in = p; step();
    endtask

    task automatic burst(int n);
        for (int i = 0; i < n; i++) px({$urandom_range(4095,0), $urandom_range(4095,0)} [35:0]);
        step(); step();
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 mode", 36'(active_mode), 36'd0);
        check("R1 valid", 36'(pix_valid_out), 36'd0);
        // R8 bypass pass-through
        cur_req = "R8";
        px(36'hABC_123_FFF); px(36'h000_001_800); burst(6);
        // R1 identity banks after reset
        cur_req = "R1";
        wr(4'hF, 32'd1);
        check("R3 mode pending", 36'(active_mode), 36'd0);
        frame_start = 1; step();
        check("R4 mode A", 36'(active_mode), 36'd1);
        px(36'h123_456_789); burst(5);
        // R3 fill bank B, queue it, still on A
        cur_req = "R3";
        wr(4'h8, {16'h16E3, 16'h06CE});
        wr(4'h9, {16'd16,   16'h024F});
        wr(4'hA, {16'hF37A, 16'hFC56});
        wr(4'hB, {16'd128,  16'h1000});
        wr(4'hC, {16'hF16A, 16'h1000});
        wr(4'hD, {16'd128,  16'hFE96});
        wr(4'hE, 32'hFFFF_FFFF);           // R2 unmapped
        wr(4'hF, 32'd2);
        check("R3 mode held", 36'(active_mode), 36'd1);
        burst(4);
        // R4 pixel on the boundary uses bank B
        cur_req = "R4";
        frame_start = 1; pix_valid_in = 1; pix_in = 36'h800_400_200; step();
        check("R4 mode B", 36'(active_mode), 36'd2);
        burst(5);
        // R5 writes into live bank B ignored
        cur_req = "R5";
        wr(4'h8, 32'h0); wr(4'h9, 32'h0);
        px(36'h800_400_200); px(36'hFFF_FFF_FFF); step(); step();
        // R6/R7 bank A with saturating, negative and half-step rows
        cur_req = "R6";
        wr(4'h0, {16'h2000, 16'h7FFF});
        wr(4'h1, {16'd100,  16'h0000});
        wr(4'h2, {16'h0000, 16'hE000});
        wr(4'h3, {16'hFFFB, 16'h1000});
        wr(4'h4, {16'h0000, 16'h1000});
        wr(4'h5, 32'h0);
        wr(4'h6, 32'hFFFF_FFFF);           // R2 unmapped
        // R10 mode write coincident with boundary
        cur_req = "R10";
        wr_en = 1; wr_addr = 4'hF; wr_data = 32'd1; frame_start = 1; step();
        check("R10 mode keeps B", 36'(active_mode), 36'd2);
        frame_start = 1; step();
        check("R10 mode A", 36'(active_mode), 36'd1);
        cur_req = "R7";
        px(36'h000_000_003); px(36'h000_000_001); px(36'h000_000_000);
        px(36'h000_FFF_FFF); px(36'h000_000_005); step(); step();
        // R2 mode value 3 behaves as bypass
        cur_req = "R2";
        wr(4'hF, 32'd3);
        frame_start = 1; step();
        check("R2 mode 3 bypass", 36'(active_mode), 36'd0);
        burst(4);
        // R9 gapped random traffic across modes
        cur_req = "R9";
        wr(4'hF, 32'd2); frame_start = 1; step();
        for (int i = 0; i < 200; i++) begin
            pix_valid_in = $urandom_range(1, 0);
            pix_in = {$urandom_range(4095,0), $urandom_range(4095,0), $urandom_range(4095,0)} [35:0];
            frame_start = (i % 50 == 25);
            if (i == 20) begin wr_en = 1; wr_addr = 4'hF; wr_data = 32'd1; end
            if (i == 100) begin wr_en = 1; wr_addr = 4'hF; wr_data = 32'd0; end
            step();
        end
        step(); step();
        report();
        $finish;
    end
endmodule